// File: doc/BRIEF.md
# Masked-Write GPIO Port Controller

This block controls sixteen general-purpose pins from a small 32-bit register bus. Each pin has an output value and an output enable. A direction register sets the enables directly. The output data register is written through a per-bit mask carried in the upper half of the same bus word, so software can set or clear any group of pins in one write without first reading the register back.

A third, read-only register returns the pin levels after a two-flop synchroniser, so a pin that has been turned into an input can be observed. Pin 0 comes out of reset as an output, which lets it act as a reset line for other logic. Software can get open-drain behaviour by holding a data bit at 0 and switching only its direction bit: an enabled pin pulls low, and a disabled pin is left to an external pull-up.

The bus is single-cycle. An access is taken on any clock edge where `bus_valid` is high. A write updates its register on that edge. A read loads `bus_rdata` on that edge, and `bus_rdata` keeps that value until the next read.

Top module: `gpio_mask_port`

## Requirements
- R1: Synchronous active-low reset sets the direction register to 0x0001 and the data register to 0x0000, with `bus_rdata` cleared. After the reset edge, `pin_oe` = 0x0001 and `pin_out` = 0x0000.
- R2: A write to offset 0x00 loads bits 15:0 of the word into the direction register. `pin_oe` shows the new value after that edge. A read of offset 0x00 returns the direction in bits 15:0 and 0 in bits 31:16.
- R3: On a write to offset 0x08, data bit n takes `bus_wdata[n]` only when `bus_wdata[n+16]` is 1. Every data bit whose mask bit is 0 keeps its value.
- R4: Writing 0x00030001 to offset 0x08 drives pin 0 to 1 and pin 1 to 0 and leaves the other fourteen output bits unchanged.
- R5: The mask field is not stored. A read of offset 0x08 returns the data bits in 15:0 and 0 in bits 31:16.
- R6: `pin_out` always equals the data register, whatever the direction. The direction bits affect only `pin_oe`.
- R7: A read of offset 0x10 returns the `pin_in` levels after two synchronising flops. For a level applied before a read at edge k, the read at edge k+1 still returns the old level and the read at edge k+2 returns the new one. Bits 31:16 read as 0, and writes to 0x10 change no register.
- R8: A read of any offset other than 0x00, 0x08 or 0x10 returns 0. A write to such an offset changes neither `pin_oe` nor `pin_out`.
- R9: Open-drain use: with a data bit held at 0, setting and clearing its direction bit switches `pin_oe` for that pin while `pin_out` stays 0.
- R10: `bus_rdata` changes only on a read edge. On idle cycles and write cycles it holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_valid | input | 1 | An access is taken on this edge |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write word (bits 31:16 are the data mask at 0x08) |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 16 | Asynchronous pin levels |
| pin_out | output | 16 | Per-pin output value |
| pin_oe | output | 16 | Per-pin output enable |

## Verification
The bench uses masks that mix set and clear bits over a non-trivial prior value. A design that ignored the mask, or shifted it by one position, would corrupt the bits that should be left alone.

It reads the data register after masked writes to check that the mask is not stored. It also changes the direction while data is set to show that `pin_out` is independent of `pin_oe`. Both faults would appear as a wrong bit at the ports.

The synchroniser is timed by reads issued back to back. A design with one flop too few or too many would return the new level one read early or one read late.

Writes to the input register and to unmapped offsets are followed by read-back and pin checks. Reset is also asserted after the registers have been changed. A design that decoded addresses loosely, or restored only part of the state, would fail one of these checks.

// File: rtl/gpio_mp_pkg.sv
// Package: shared widths, register offsets and the register-select type
// for the masked-write GPIO port.
// Assumes byte offsets and a 32-bit bus word.
package gpio_mp_pkg;

    localparam int BUS_W    = 32;
    localparam int MASK_LSB = 16;

    localparam int OFS_DIR  = 'h00;
    localparam int OFS_DOUT = 'h08;
    localparam int OFS_PIN  = 'h10;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_DIR  = 2'd1,
        SEL_DOUT = 2'd2,
        SEL_PIN  = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/gpio_mp_sync.sv
// Module: gpio_mp_sync
// A chain of flops that brings asynchronous pin levels into the clock domain.
// Assumes STAGES >= 1. Every stage clears to 0 on reset.
module gpio_mp_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // Capture the raw asynchronous input.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= '0;
                else        chain[g] <= din;
            end
        end else begin : g_next
            // Pass the value on from the previous stage.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= '0;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/gpio_mp_regs.sv
// Module: gpio_mp_regs
// Holds the direction register and the data register.
// The direction register is written as a whole word. Each data bit n is
// written only when its mask bit (wdata[16+n]) is set.
// Assumes PINS <= 16, so that the mask fits in the upper half of the word.
module gpio_mp_regs
    import gpio_mp_pkg::*;
#(
    parameter int              PINS      = 16,
    parameter logic [PINS-1:0] DIR_RESET = PINS'(1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dir_we,
    input  logic             dout_we,
    input  logic [BUS_W-1:0] wdata,
    output logic [PINS-1:0]  dir_q,
    output logic [PINS-1:0]  dout_q
);

    // Load the direction register on a write, and restore its default on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      dir_q <= DIR_RESET;
        else if (dir_we) dir_q <= wdata[PINS-1:0];
    end

    for (genvar n = 0; n < PINS; n++) begin : g_dbit
        logic bit_we;
        assign bit_we = dout_we & wdata[MASK_LSB + n];

        // Update one data bit, and only when its mask bit is set.
        always_ff @(posedge clk) begin
            if (!rst_n)      dout_q[n] <= 1'b0;
            else if (bit_we) dout_q[n] <= wdata[n];
        end
    end

endmodule

// File: rtl/gpio_mp_rdmux.sv
// Module: gpio_mp_rdmux
// Selects the register to read, widens it to the bus word with zeros above,
// and registers it. The result is held until the next read.
// Unmapped offsets read as 0.
module gpio_mp_rdmux
    import gpio_mp_pkg::*;
#(
    parameter int PINS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  reg_sel_e         sel,
    input  logic [PINS-1:0]  dir_q,
    input  logic [PINS-1:0]  dout_q,
    input  logic [PINS-1:0]  pin_q,
    output logic [BUS_W-1:0] rdata
);

    logic [BUS_W-1:0] rd_next;

    // Choose the source for the read and zero-extend it.
    always_comb begin
        unique case (sel)
            SEL_DIR:  rd_next = BUS_W'(dir_q);
            SEL_DOUT: rd_next = BUS_W'(dout_q);
            SEL_PIN:  rd_next = BUS_W'(pin_q);
            default:  rd_next = '0;
        endcase
    end

    // Load the read data only on a read edge.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_next;
    end

endmodule

// File: rtl/gpio_mask_port.sv
// Module: gpio_mask_port (top)
// Sixteen-pin GPIO controller with a single-cycle register bus.
// Register offsets: 0x00 direction, 0x08 masked data output, 0x10 synchronised
// pin input (read-only). The full address is decoded.
// Assumes a synchronous active-low reset, and PINS <= 16.
module gpio_mask_port
    import gpio_mp_pkg::*;
#(
    parameter int              PINS        = 16,
    parameter int              ADDR_W      = 8,
    parameter int              SYNC_STAGES = 2,
    parameter logic [PINS-1:0] DIR_RESET   = PINS'(1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_oe
);

    reg_sel_e        sel;
    logic            dir_we;
    logic            dout_we;
    logic            rd_en;
    logic [PINS-1:0] dir_q;
    logic [PINS-1:0] dout_q;
    logic [PINS-1:0] pin_q;

    // Decode the full address into a register select.
    always_comb begin
        if      (bus_addr == ADDR_W'(OFS_DIR))  sel = SEL_DIR;
        else if (bus_addr == ADDR_W'(OFS_DOUT)) sel = SEL_DOUT;
        else if (bus_addr == ADDR_W'(OFS_PIN))  sel = SEL_PIN;
        else                                    sel = SEL_NONE;
    end

    // Form the per-register write strobes and the read strobe.
    always_comb begin
        dir_we  = bus_valid &  bus_write & (sel == SEL_DIR);
        dout_we = bus_valid &  bus_write & (sel == SEL_DOUT);
        rd_en   = bus_valid & ~bus_write;
    end

    gpio_mp_regs #(
        .PINS      (PINS),
        .DIR_RESET (DIR_RESET)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .dir_we  (dir_we),
        .dout_we (dout_we),
        .wdata   (bus_wdata),
        .dir_q   (dir_q),
        .dout_q  (dout_q)
    );

    gpio_mp_sync #(
        .W      (PINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_in),
        .dout  (pin_q)
    );

    gpio_mp_rdmux #(
        .PINS (PINS)
    ) u_rdmux (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_en  (rd_en),
        .sel    (sel),
        .dir_q  (dir_q),
        .dout_q (dout_q),
        .pin_q  (pin_q),
        .rdata  (bus_rdata)
    );

    assign pin_out = dout_q;
    assign pin_oe  = dir_q;

endmodule

// File: rtl/gpio_mask_port_chk.sv
// Module: gpio_mask_port_chk
// Checker for gpio_mask_port. It watches only the top-level ports and is
// attached to the top module by the bind statement at the end of this file.
module gpio_mask_port_chk #(
    parameter int              PINS      = 16,
    parameter int              ADDR_W    = 8,
    parameter logic [PINS-1:0] DIR_RESET = PINS'(1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [PINS-1:0]   pin_out,
    input logic [PINS-1:0]   pin_oe
);

    localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'('h00);
    localparam logic [ADDR_W-1:0] A_DOUT = ADDR_W'('h08);
    localparam logic [ADDR_W-1:0] A_PIN  = ADDR_W'('h10);

    logic            seen_clk;
    logic [PINS-1:0] wmask;
    logic [PINS-1:0] wval;
    logic            unmapped;

    // Mark that at least one clock edge has occurred, so $past is valid.
    always_ff @(posedge clk) seen_clk <= 1'b1;

    assign wmask    = bus_wdata[16 +: PINS];
    assign wval     = bus_wdata[PINS-1:0];
    assign unmapped = (bus_addr != A_DIR) && (bus_addr != A_DOUT) && (bus_addr != A_PIN);

    // R1
    reset_default_chk: assert property (@(posedge clk)
        (seen_clk && $past(!rst_n)) |-> (pin_oe == DIR_RESET && pin_out == '0 && bus_rdata == '0));

    // R2
    dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == A_DIR) |=> (pin_oe == $past(wval)));

    // R3
    masked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == A_DOUT) |=>
        (pin_out == (($past(pin_out) & ~$past(wmask)) | ($past(wval) & $past(wmask)))));

    // R7 R8
    inert_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && (unmapped || bus_addr == A_PIN)) |=>
        ($stable(pin_out) && $stable(pin_oe)));

    // R8
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && unmapped) |=> (bus_rdata == '0));

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && !bus_write) |=> $stable(bus_rdata));

    // R6 R9
    dir_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == A_DIR) |=> $stable(pin_out));

endmodule

bind gpio_mask_port gpio_mask_port_chk #(
    .PINS      (PINS),
    .ADDR_W    (ADDR_W),
    .DIR_RESET (DIR_RESET)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
);

// File: tb/test_gpio_mask_port.sv
// Directed bench for gpio_mask_port.
// Inputs are driven on the falling edge and outputs are sampled on the
// following falling edge.
module test_gpio_mask_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out;
    logic [15:0] pin_oe;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // 125 MHz clock: 8 ns period.
    always #4 clk = ~clk;

    gpio_mask_port i_gpio_mask_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        logic [31:0] r;
        check("R1 oe after reset", 32'(pin_oe), 32'h0001);
        check("R1 out after reset", 32'(pin_out), 32'h0000);
        check("R1 rdata after reset", bus_rdata, 32'h0);
        rd(8'h00, r); check("R1 dir readback", r, 32'h0000_0001);
        rd(8'h08, r); check("R1 data readback", r, 32'h0);
    endtask

    task automatic t_dir();
        logic [31:0] r;
        wr(8'h00, 32'hFFFF_A5C3);
        check("R2 oe after dir write", 32'(pin_oe), 32'hA5C3);
        rd(8'h00, r); check("R2 dir readback upper zero", r, 32'h0000_A5C3);
        check("R6 out unchanged by dir", 32'(pin_out), 32'h0);
    endtask

    task automatic t_masked();
        logic [31:0] r;
        wr(8'h08, 32'hFFFF_0F0F);
        check("R3 full-mask write", 32'(pin_out), 32'h0F0F);
        wr(8'h08, 32'h00F0_FFFF);
        check("R3 partial mask sets 7:4 only", 32'(pin_out), 32'h0FFF);
        wr(8'h08, 32'h8001_0000);
        check("R3 mask clears 15 and 0", 32'(pin_out), 32'h0FFE);
        wr(8'h08, 32'h0000_FFFF);
        check("R3 empty mask no change", 32'(pin_out), 32'h0FFE);
        rd(8'h08, r); check("R5 data readback no mask", r, 32'h0000_0FFE);
    endtask

    task automatic t_example();
        wr(8'h08, 32'hFFFF_5556);
        wr(8'h08, 32'h0003_0001);
        check("R4 example write", 32'(pin_out), 32'h5555);
    endtask

    task automatic t_indep();
        wr(8'h08, 32'hFFFF_C33C);
        wr(8'h00, 32'h0000_0000);
        check("R6 out with oe all zero", 32'(pin_out), 32'hC33C);
        check("R6 oe all zero", 32'(pin_oe), 32'h0);
        wr(8'h00, 32'h0000_FFFF);
        check("R6 out with oe all one", 32'(pin_out), 32'hC33C);
    endtask

    task automatic t_open_drain();
        wr(8'h08, 32'h0020_0000);
        wr(8'h00, 32'h0000_0020);
        check("R9 drive low oe", 32'(pin_oe) & 32'h20, 32'h20);
        check("R9 drive low out", 32'(pin_out) & 32'h20, 32'h0);
        wr(8'h00, 32'h0000_0000);
        check("R9 release oe", 32'(pin_oe) & 32'h20, 32'h0);
        check("R9 release out", 32'(pin_out) & 32'h20, 32'h0);
    endtask

    task automatic t_input();
        logic [31:0] r;
        pin_in = 16'h1234;
        rd(8'h10, r);
        rd(8'h10, r); check("R7 second read still old", r, 32'h0);
        rd(8'h10, r); check("R7 third read new level", r, 32'h0000_1234);
        wr(8'h00, 32'h0000_00FF);
        wr(8'h08, 32'hFFFF_0AAA);
        wr(8'h10, 32'hFFFF_FFFF);
        check("R7 write to input keeps out", 32'(pin_out), 32'h0AAA);
        check("R7 write to input keeps oe", 32'(pin_oe), 32'h00FF);
        rd(8'h10, r); check("R7 input readback after write", r, 32'h0000_1234);
    endtask

    task automatic t_unmapped();
        logic [31:0] r;
        wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h09, 32'hFFFF_FFFF);
        wr(8'h88, 32'hFFFF_FFFF);
        check("R8 unmapped write out", 32'(pin_out), 32'h0AAA);
        check("R8 unmapped write oe", 32'(pin_oe), 32'h00FF);
        rd(8'h00, r);
        rd(8'h0C, r); check("R8 unmapped read 0x0C", r, 32'h0);
        rd(8'h80, r); check("R8 unmapped read 0x80", r, 32'h0);
    endtask

    task automatic t_hold();
        logic [31:0] r;
        rd(8'h08, r); check("R10 read value", r, 32'h0000_0AAA);
        @(negedge clk);
        check("R10 hold idle", bus_rdata, 32'h0000_0AAA);
        wr(8'h08, 32'hFFFF_0000);
        check("R10 hold on write", bus_rdata, 32'h0000_0AAA);
    endtask

    task automatic t_reset_again();
        wr(8'h00, 32'h0000_F0F0);
        wr(8'h08, 32'hFFFF_FFFF);
        do_reset();
        check("R1 oe after mid reset", 32'(pin_oe), 32'h0001);
        check("R1 out after mid reset", 32'(pin_out), 32'h0);
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        t_reset();
        t_dir();
        t_masked();
        t_example();
        t_indep();
        t_open_drain();
        t_input();
        t_unmapped();
        t_hold();
        t_reset_again();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule